// File: doc/BRIEF.md
# Memory-Card Command Issue and Response Capture Unit

This unit is the command half of a memory-card host's register logic. Software programs a 32-bit command argument as two 16-bit halves and sets an enable bit. Writing a 16-bit command word then launches a command. The unit breaks the word into its fields and presents them, with the argument, to the card side for one cycle. It then waits for the card's answer, which arrives as a burst of up to sixteen bytes with a byte count and a valid strobe.

When the answer arrives, the unit checks the byte count against the length the response type needs. It inspects the card-status word for error bits that depend on the response type. It packs the bytes into eight 16-bit response registers and sets completion, timeout and error flags in a status word. Software clears the status word one bit at a time by writing ones. Any status bit that is also set in the enable mask drives the single interrupt line.

Top module: `cmd_resp_unit`

## Requirements
- R1: A command word carries the command index in bits 5:0, an init flag in bit 7, the response type in bits 10:8, a busy flag in bit 11, the command type in bits 13:12 and the data direction in bit 15. In the cycle that `cmd_go` is high, these fields appear on `cmd_index`, `cmd_init`, `cmd_rtype`, `cmd_busy` (see R3), `cmd_ctype` and `cmd_dir`, and `cmd_arg` shows the argument.
- R2: Writing address 0 starts a command only if control bit 11 (address 3) is set and no command is outstanding. Otherwise the write changes nothing: no `cmd_go`, no `busy`, and the address-0 readback is unchanged. An accepted write clears all eight response registers, stores the word for readback at address 0, pulses `cmd_go` for one cycle and holds `busy` high until the response strobe.
- R3: `cmd_busy` is high only when the busy flag is set and the response type is 1. The busy flag has no effect with any other type.
- R4: Types 1, 3 and 6 need at least 4 response bytes and type 2 needs 16. A shorter count sets status bit 7 (timeout) instead of bit 0, and the response registers stay zero.
- R5: For a type-3 response, status bit 12 is set when bit 31 of the card word is clear. The card word is byte0 in bits 31:24 down to byte3 in bits 7:0.
- R6: Status bit 14 is set when a type-1 card word ANDed with 0xFDF90000 is nonzero, or when a type-6 response's low 16 bits ANDed with 0xE008 are nonzero. Types 2 and 3 never set bit 14.
- R7: A response without a timeout sets status bit 0. If the command index is 12, it sets bits 0 and 2 together instead.
- R8: Response byte pair k (bytes 2k and 2k+1, the even byte in the high half) lands in response register 7−k (address 8+7−k). A short response fills registers 7 and 6 only, and a long response fills all eight.
- R9: Writing the status word (address 4) clears each bit written as 1. A bit that a response sets in the same cycle stays set.
- R10: `irq` is high exactly when the status word ANDed with the mask (address 5) is nonzero, and it follows a change of either.
- R11: The argument low half (address 1) and high half (address 2) are written separately, and each write leaves the other half unchanged.
- R12: Reset clears the argument, the control bit, the stored command, the status, the mask and every response register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register word address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr` (combinational) |
| irq | output | 1 | Interrupt: status AND mask nonzero |
| busy | output | 1 | A command is waiting for its response |
| cmd_go | output | 1 | One-cycle command launch pulse |
| cmd_index | output | 6 | Command index |
| cmd_arg | output | 32 | Command argument |
| cmd_rtype | output | 3 | Response type |
| cmd_busy | output | 1 | Busy-signalling type-1 command |
| cmd_ctype | output | 2 | Command type |
| cmd_dir | output | 1 | Data direction |
| cmd_init | output | 1 | Init flag |
| rsp_valid | input | 1 | Response bytes valid |
| rsp_len | input | 5 | Number of response bytes |
| rsp_data | input | 128 | Response bytes, byte i in bits 8i+7:8i |

## Verification
The bench targets the length thresholds, one byte below and at the required count. A design that compares off by one flags timeouts on good answers or misses a truncated long response. It probes the card-status masks with bits just outside them (bit 25 for type 1, high bytes for type 6) and with the one low bit that is inside (bit 3 for type 6). A design with the wrong mask raises false errors or misses real ones. It writes a clear in the same cycle a completion arrives, to catch a design that lets the clear win and loses the event. It also checks reversed pair placement, including the top byte of a long response, which a design with byte order swapped would put in the wrong half.

// File: rtl/cmdrsp_pkg.sv
package cmdrsp_pkg;

   localparam int REG_W  = 16;
   localparam int ADDR_W = 4;

   // register word addresses
   localparam logic [ADDR_W-1:0] A_CMD    = 4'd0;
   localparam logic [ADDR_W-1:0] A_ARG_LO = 4'd1;
   localparam logic [ADDR_W-1:0] A_ARG_HI = 4'd2;
   localparam logic [ADDR_W-1:0] A_CTRL   = 4'd3;
   localparam logic [ADDR_W-1:0] A_STAT   = 4'd4;
   localparam logic [ADDR_W-1:0] A_MASK   = 4'd5;

   // control and status bit positions
   localparam int EN_BIT      = 11;
   localparam int ST_DONE     = 0;
   localparam int ST_STOP     = 2;
   localparam int ST_TIMEOUT  = 7;
   localparam int ST_OCRBUSY  = 12;
   localparam int ST_CARDERR  = 14;

   // response type codes
   localparam logic [2:0] RT_NONE = 3'd0;
   localparam logic [2:0] RT_R1   = 3'd1;
   localparam logic [2:0] RT_R2   = 3'd2;
   localparam logic [2:0] RT_R3   = 3'd3;
   localparam logic [2:0] RT_R6   = 3'd6;

   typedef struct packed {
      logic       dir;
      logic [1:0] ctype;
      logic       busy;
      logic [2:0] rtype;
      logic       init;
      logic [5:0] idx;
   } cmd_fields_t;

endpackage

// File: rtl/cmdrsp_decode.sv
module cmdrsp_decode
   import cmdrsp_pkg::*;
(
   input  logic [REG_W-1:0] word,
   output cmd_fields_t      fields,
   output logic             busy_wait
);

   logic unused_rsvd;

   assign fields.idx   = word[5:0];
   assign fields.init  = word[7];
   assign fields.rtype = word[10:8];
   assign fields.busy  = word[11];
   assign fields.ctype = word[13:12];
   assign fields.dir   = word[15];

   // only a type-1 response has a busy-signalling variant
   assign busy_wait   = word[11] && (word[10:8] == RT_R1);
   assign unused_rsvd = word[14] ^ word[6];

endmodule

// File: rtl/cmdrsp_resp_eval.sv
module cmdrsp_resp_eval
   import cmdrsp_pkg::*;
#(
   parameter int          NUM_RSP_REGS = 8,
   parameter int          SHORT_BYTES  = 4,
   parameter logic [5:0]  STOP_IDX     = 6'd12,
   parameter logic [31:0] R1_ERR_MASK  = 32'hFDF9_0000,
   parameter logic [15:0] R6_ERR_MASK  = 16'hE008,
   localparam int RSP_BYTES = 2 * NUM_RSP_REGS,
   localparam int LEN_W     = $clog2(RSP_BYTES + 1)
)(
   input  cmd_fields_t                      fields,
   input  logic [LEN_W-1:0]                 len,
   input  logic [8*RSP_BYTES-1:0]           data,
   output logic [REG_W-1:0]                 set_bits,
   output logic [NUM_RSP_REGS-1:0]          cap_en,
   output logic [NUM_RSP_REGS*REG_W-1:0]    cap_val
);

   localparam logic [LEN_W-1:0] SHORT_LEN = LEN_W'(SHORT_BYTES);
   localparam logic [LEN_W-1:0] LONG_LEN  = LEN_W'(RSP_BYTES);
   localparam int               SHORT_PAIRS = SHORT_BYTES / 2;

   logic        is_short, is_long, timeout, card_err, ocr_wait;
   logic [31:0] card_word;

   always_comb begin
      is_short  = (fields.rtype == RT_R1) || (fields.rtype == RT_R3) ||
                  (fields.rtype == RT_R6);
      is_long   = (fields.rtype == RT_R2);
      timeout   = (is_short && (len < SHORT_LEN)) || (is_long && (len < LONG_LEN));
      card_word = {data[7:0], data[15:8], data[23:16], data[31:24]};
      card_err  = !timeout &&
                  (((fields.rtype == RT_R1) && |(card_word & R1_ERR_MASK)) ||
                   ((fields.rtype == RT_R6) && |(card_word[15:0] & R6_ERR_MASK)));
      ocr_wait  = !timeout && (fields.rtype == RT_R3) && !card_word[31];

      set_bits = '0;
      if (timeout) begin
         set_bits[ST_TIMEOUT] = 1'b1;
      end else begin
         set_bits[ST_DONE] = 1'b1;
         if (fields.idx == STOP_IDX) set_bits[ST_STOP] = 1'b1;
      end
      if (card_err) set_bits[ST_CARDERR] = 1'b1;
      if (ocr_wait) set_bits[ST_OCRBUSY] = 1'b1;
   end

   // byte pair k lands in register NUM_RSP_REGS-1-k, even byte high
   for (genvar k = 0; k < NUM_RSP_REGS; k++) begin : g_pair
      localparam int J = NUM_RSP_REGS - 1 - k;
      assign cap_val[J*REG_W +: REG_W] = {data[16*k +: 8], data[16*k+8 +: 8]};
      if (k < SHORT_PAIRS) begin : g_short
         assign cap_en[J] = !timeout && (is_short || is_long);
      end else begin : g_long_only
         assign cap_en[J] = !timeout && is_long;
      end
   end

endmodule

// File: rtl/cmdrsp_status.sv
module cmdrsp_status
   import cmdrsp_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             set_en,
   input  logic [REG_W-1:0] set_bits,
   input  logic             clr_en,
   input  logic [REG_W-1:0] clr_bits,
   input  logic             mask_we,
   input  logic [REG_W-1:0] mask_wdata,
   output logic [REG_W-1:0] stat,
   output logic [REG_W-1:0] mask,
   output logic             irq
);

   logic [REG_W-1:0] clr_vec, set_vec;

   assign clr_vec = clr_en ? clr_bits : '0;
   assign set_vec = set_en ? set_bits : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat <= '0;
         mask <= '0;
      end else begin
         stat <= (stat & ~clr_vec) | set_vec;
         if (mask_we) mask <= mask_wdata;
      end
   end

   assign irq = |(stat & mask);

   // R9: bits written as one are gone a cycle later when nothing sets them
   p_w1c_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_en && !set_en) |=> ((stat & $past(clr_bits)) == '0));

   // R9: a set in the same cycle as a clear survives
   p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
      set_en |=> ((stat & $past(set_bits)) == $past(set_bits)));

endmodule

// File: rtl/cmd_resp_unit.sv
module cmd_resp_unit
   import cmdrsp_pkg::*;
#(
   parameter int          NUM_RSP_REGS = 8,
   parameter int          SHORT_BYTES  = 4,
   parameter logic [5:0]  STOP_IDX     = 6'd12,
   parameter logic [31:0] R1_ERR_MASK  = 32'hFDF9_0000,
   parameter logic [15:0] R6_ERR_MASK  = 16'hE008,
   localparam int RSP_BYTES = 2 * NUM_RSP_REGS,
   localparam int LEN_W     = $clog2(RSP_BYTES + 1)
)(
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_en,
   input  logic [3:0]              addr,
   input  logic [15:0]             wdata,
   output logic [15:0]             rdata,
   output logic                    irq,
   output logic                    busy,
   output logic                    cmd_go,
   output logic [5:0]              cmd_index,
   output logic [31:0]             cmd_arg,
   output logic [2:0]              cmd_rtype,
   output logic                    cmd_busy,
   output logic [1:0]              cmd_ctype,
   output logic                    cmd_dir,
   output logic                    cmd_init,
   input  logic                    rsp_valid,
   input  logic [LEN_W-1:0]        rsp_len,
   input  logic [8*RSP_BYTES-1:0]  rsp_data
);

   localparam logic [LEN_W-1:0] LONG_LEN = LEN_W'(RSP_BYTES);
   localparam int RSP_BASE = 8;

   // elaboration-time parameter checks
   if (NUM_RSP_REGS < 2 || NUM_RSP_REGS > 8) begin : g_bad_nregs
      $error("NUM_RSP_REGS must lie in 2..8");
   end
   if (SHORT_BYTES < 4 || SHORT_BYTES > RSP_BYTES || (SHORT_BYTES % 2) != 0) begin : g_bad_short
      $error("SHORT_BYTES must be even, at least 4 and fit the register set");
   end

   logic              en_q, busy_q, go_q;
   logic [31:0]       arg_q;
   logic [REG_W-1:0]  cmd_q;
   cmd_fields_t       fields;
   logic              busy_wait;
   logic              accept, resp_fire;
   logic [REG_W-1:0]  set_bits, stat, mask;
   logic [NUM_RSP_REGS-1:0]       cap_en;
   logic [NUM_RSP_REGS*REG_W-1:0] cap_val, rsp_flat;

   assign accept    = wr_en && (addr == A_CMD) && en_q && !busy_q;
   assign resp_fire = busy_q && rsp_valid;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         busy_q <= 1'b0;
         go_q   <= 1'b0;
         arg_q  <= '0;
         cmd_q  <= '0;
      end else begin
         go_q <= accept;
         if (accept) begin
            cmd_q  <= wdata;
            busy_q <= 1'b1;
         end else if (resp_fire) begin
            busy_q <= 1'b0;
         end
         if (wr_en && addr == A_CTRL)   en_q          <= wdata[EN_BIT];
         if (wr_en && addr == A_ARG_LO) arg_q[15:0]   <= wdata;
         if (wr_en && addr == A_ARG_HI) arg_q[31:16]  <= wdata;
      end
   end

   cmdrsp_decode u_decode (
      .word      (cmd_q),
      .fields    (fields),
      .busy_wait (busy_wait)
   );

   cmdrsp_resp_eval #(
      .NUM_RSP_REGS (NUM_RSP_REGS),
      .SHORT_BYTES  (SHORT_BYTES),
      .STOP_IDX     (STOP_IDX),
      .R1_ERR_MASK  (R1_ERR_MASK),
      .R6_ERR_MASK  (R6_ERR_MASK)
   ) u_eval (
      .fields   (fields),
      .len      (rsp_len),
      .data     (rsp_data),
      .set_bits (set_bits),
      .cap_en   (cap_en),
      .cap_val  (cap_val)
   );

   cmdrsp_status u_status (
      .clk        (clk),
      .rst_n      (rst_n),
      .set_en     (resp_fire),
      .set_bits   (set_bits),
      .clr_en     (wr_en && (addr == A_STAT)),
      .clr_bits   (wdata),
      .mask_we    (wr_en && (addr == A_MASK)),
      .mask_wdata (wdata),
      .stat       (stat),
      .mask       (mask),
      .irq        (irq)
   );

   // response registers, one per generate slot
   for (genvar j = 0; j < NUM_RSP_REGS; j++) begin : g_rsp
      logic [REG_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                     q <= '0;
         else if (accept)                q <= '0;
         else if (resp_fire && cap_en[j]) q <= cap_val[j*REG_W +: REG_W];
      end
      assign rsp_flat[j*REG_W +: REG_W] = q;
   end

   // register readback
   always_comb begin
      rdata = '0;
      if (addr[3]) begin
         if (int'(addr[2:0]) < NUM_RSP_REGS)
            rdata = rsp_flat[int'(addr[2:0])*REG_W +: REG_W];
      end else begin
         case (addr)
            A_CMD:    rdata = cmd_q;
            A_ARG_LO: rdata = arg_q[15:0];
            A_ARG_HI: rdata = arg_q[31:16];
            A_CTRL:   rdata = REG_W'(en_q) << EN_BIT;
            A_STAT:   rdata = stat;
            A_MASK:   rdata = mask;
            default:  rdata = '0;
         endcase
      end
   end

   assign busy      = busy_q;
   assign cmd_go    = go_q;
   assign cmd_arg   = arg_q;
   assign cmd_index = fields.idx;
   assign cmd_rtype = fields.rtype;
   assign cmd_busy  = busy_wait;
   assign cmd_ctype = fields.ctype;
   assign cmd_dir   = fields.dir;
   assign cmd_init  = fields.init;

   // R2: a command write with the enable bit clear launches nothing
   p_cmd_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == A_CMD && !en_q) |=> !cmd_go);

   // R2: the launch strobe lasts one cycle
   p_go_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_go |=> !cmd_go);

   // R2: accepted command empties the response registers and waits
   p_clear_on_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == A_CMD && en_q && !busy) |=> (busy && rsp_flat == '0));

   // R3: the busy variant exists only for type 1
   p_busy_variant_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_go && cmd_busy) |-> (cmd_rtype == RT_R1));

   // R4: a truncated long response reports timeout
   p_long_timeout_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && rsp_valid && cmd_rtype == RT_R2 && rsp_len < LONG_LEN) |=> stat[ST_TIMEOUT]);

   // R7: every response ends the wait with done or timeout recorded
   p_complete_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && rsp_valid) |=> (!busy && (stat[ST_DONE] || stat[ST_TIMEOUT])));

endmodule

// File: tb/cmd_resp_unit_tb.sv
`timescale 1ns/1ps
module cmd_resp_unit_tb;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         wr_en = 1'b0;
   logic [3:0]   addr = '0;
   logic [15:0]  wdata = '0;
   logic [15:0]  rdata;
   logic         irq, busy, cmd_go, cmd_busy, cmd_dir, cmd_init;
   logic [5:0]   cmd_index;
   logic [31:0]  cmd_arg;
   logic [2:0]   cmd_rtype;
   logic [1:0]   cmd_ctype;
   logic         rsp_valid = 1'b0;
   logic [4:0]   rsp_len = '0;
   logic [127:0] rsp_data = '0;

   int n_checks = 0;
   int n_fails  = 0;
   bit finished = 0;

   // captured at the launch cycle
   logic        g_go, g_busy, g_dir, g_init, g_bsy;
   logic [5:0]  g_idx;
   logic [2:0]  g_rt;
   logic [1:0]  g_ct;
   logic [31:0] g_arg;

   always #2.5 clk = ~clk;

   cmd_resp_unit u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .rdata(rdata), .irq(irq), .busy(busy), .cmd_go(cmd_go),
      .cmd_index(cmd_index), .cmd_arg(cmd_arg), .cmd_rtype(cmd_rtype),
      .cmd_busy(cmd_busy), .cmd_ctype(cmd_ctype), .cmd_dir(cmd_dir),
      .cmd_init(cmd_init), .rsp_valid(rsp_valid), .rsp_len(rsp_len),
      .rsp_data(rsp_data)
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [15:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [15:0] v);
      @(negedge clk);
      addr = a;
      #1 v = rdata;
   endtask

   task automatic send_cmd(input logic [15:0] w);
      wr(4'd0, w);
      g_go = cmd_go; g_busy = busy; g_idx = cmd_index; g_rt = cmd_rtype;
      g_ct = cmd_ctype; g_dir = cmd_dir; g_init = cmd_init; g_bsy = cmd_busy;
      g_arg = cmd_arg;
   endtask

   task automatic give_rsp(input int len, input logic [127:0] d);
      rsp_valid = 1'b1; rsp_len = 5'(len); rsp_data = d;
      @(negedge clk);
      rsp_valid = 1'b0;
   endtask

   task automatic issue(input logic [15:0] w, input int len, input logic [127:0] d);
      send_cmd(w);
      give_rsp(len, d);
   endtask

   function automatic logic [127:0] b4(input logic [7:0] b0, input logic [7:0] b1,
                                      input logic [7:0] b2, input logic [7:0] b3);
      return {96'h0, b3, b2, b1, b0};
   endfunction

   task automatic chk_stat(input string req, input logic [15:0] exp);
      logic [15:0] v;
      rd(4'd4, v);
      chk(req, "status", v, exp);
      wr(4'd4, 16'hFFFF);
   endtask

   task automatic t_reset;
      logic [15:0] v;
      rd(4'd4, v); chk("R12", "status after reset", v, 0);
      rd(4'd3, v); chk("R12", "control after reset", v, 0);
      rd(4'd1, v); chk("R12", "arg low after reset", v, 0);
      rd(4'd15, v); chk("R12", "rsp0 after reset", v, 0);
      chk("R12", "irq/busy after reset", {irq, busy}, 0);
   endtask

   task automatic t_arg;
      logic [15:0] v;
      wr(4'd1, 16'h1234); wr(4'd2, 16'hABCD);
      rd(4'd1, v); chk("R11", "arg low", v, 16'h1234);
      wr(4'd1, 16'h5555);
      rd(4'd2, v); chk("R11", "arg high kept", v, 16'hABCD);
      rd(4'd1, v); chk("R11", "arg low replaced", v, 16'h5555);
   endtask

   task automatic t_disabled;
      logic [15:0] v;
      send_cmd(16'h0111);
      chk("R2", "go/busy while disabled", {g_go, g_busy}, 0);
      rd(4'd0, v); chk("R2", "cmd readback unchanged", v, 0);
      rd(4'd4, v); chk("R2", "status untouched", v, 0);
      wr(4'd3, 16'h0800);
      rd(4'd3, v); chk("R2", "enable readback", v, 16'h0800);
   endtask

   task automatic t_r1_basic;
      logic [15:0] v;
      send_cmd(16'h9191);
      chk("R1", "go", g_go, 1);
      chk("R1", "index", g_idx, 17);
      chk("R1", "rtype/ctype/dir/init", {g_rt, g_ct, g_dir, g_init}, {3'd1, 2'd1, 1'b1, 1'b1});
      chk("R1", "arg", g_arg, 32'hABCD5555);
      chk("R3", "busy flag clear", g_bsy, 0);
      // a second command while waiting is dropped
      wr(4'd0, 16'h0110);
      chk("R2", "no relaunch while busy", cmd_go, 0);
      give_rsp(6, {80'h0, 8'hBB, 8'hAA, 8'h00, 8'h09, 8'h00, 8'h00});
      chk("R2", "busy cleared", busy, 0);
      rd(4'd0, v); chk("R2", "first command kept", v, 16'h9191);
      rd(4'd14, v); chk("R8", "rsp6 pair1", v, 16'h0900);
      rd(4'd15, v); chk("R8", "rsp7 pair0", v, 16'h0000);
      rd(4'd13, v); chk("R8", "rsp5 not filled by short", v, 0);
      chk_stat("R7", 16'h0001);
   endtask

   task automatic t_r1_err;
      issue(16'h0111, 4, b4(8'h02, 8'h00, 8'h00, 8'h00));
      chk_stat("R6", 16'h0001);                 // bit 25 outside mask
      issue(16'h0111, 4, b4(8'h80, 8'h00, 8'h00, 8'h00));
      chk_stat("R6", 16'h4001);
   endtask

   task automatic t_busy_flag;
      send_cmd(16'h0907);
      chk("R3", "type1 busy variant", g_bsy, 1);
      give_rsp(4, '0);
      wr(4'd4, 16'hFFFF);
      send_cmd(16'h0A02);
      chk("R3", "busy flag ignored for type2", g_bsy, 0);
      give_rsp(16, '0);
      wr(4'd4, 16'hFFFF);
   endtask

   task automatic t_long;
      logic [127:0] d;
      logic [15:0] v;
      for (int i = 0; i < 16; i++) d[8*i +: 8] = 8'h10 + 8'(i);
      d[7:0] = 8'hFF;
      issue(16'h0202, 16, d);
      rd(4'd15, v); chk("R8", "rsp7 long", v, 16'hFF11);
      rd(4'd8, v);  chk("R8", "rsp0 long", v, 16'h1E1F);
      rd(4'd11, v); chk("R8", "rsp3 long", v, 16'h1819);
      chk_stat("R6", 16'h0001);                 // long never flags card error
      issue(16'h0202, 15, d);
      rd(4'd15, v); chk("R4", "rsp7 cleared on timeout", v, 0);
      rd(4'd8, v);  chk("R4", "rsp0 cleared on timeout", v, 0);
      chk_stat("R4", 16'h0080);
   endtask

   task automatic t_r3;
      issue(16'h0329, 3, b4(8'h80, 8'h00, 8'h00, 8'h00));
      chk_stat("R4", 16'h0080);
      issue(16'h0329, 4, b4(8'h7F, 8'hFF, 8'h00, 8'h00));
      chk_stat("R5", 16'h1001);
      issue(16'h0329, 4, b4(8'h80, 8'hFF, 8'h00, 8'h00));
      chk_stat("R5", 16'h0001);
   endtask

   task automatic t_r6;
      issue(16'h0603, 4, b4(8'h00, 8'h00, 8'h20, 8'h00));
      chk_stat("R6", 16'h4001);
      issue(16'h0603, 4, b4(8'hFF, 8'hFF, 8'h10, 8'h07));
      chk_stat("R6", 16'h0001);
      issue(16'h0603, 4, b4(8'h00, 8'h00, 8'h00, 8'h08));
      chk_stat("R6", 16'h4001);
   endtask

   task automatic t_stop_and_none;
      logic [15:0] v;
      issue(16'h090C, 4, '0);
      chk_stat("R7", 16'h0005);
      issue(16'h090C, 2, '0);
      chk_stat("R7", 16'h0080);
      issue(16'h0000, 0, {128{1'b1}});
      rd(4'd15, v); chk("R8", "no capture for type0", v, 0);
      chk_stat("R7", 16'h0001);
   endtask

   task automatic t_w1c_irq;
      logic [15:0] v;
      issue(16'h0111, 4, b4(8'h80, 8'h00, 8'h00, 8'h00));
      wr(4'd5, 16'h4000);
      chk("R10", "irq on masked error", irq, 1);
      wr(4'd4, 16'h0001);
      rd(4'd4, v); chk("R9", "partial clear", v, 16'h4000);
      chk("R10", "irq still high", irq, 1);
      wr(4'd4, 16'h4000);
      chk("R10", "irq low after clear", irq, 0);
      // clear in the same cycle a completion lands
      send_cmd(16'h0111);
      wr_en = 1'b1; addr = 4'd4; wdata = 16'hFFFF;
      give_rsp(4, '0);
      wr_en = 1'b0;
      rd(4'd4, v); chk("R9", "set wins over clear", v, 16'h0001);
      chk("R10", "irq off while bit unmasked", irq, 0);
      wr(4'd5, 16'h0001);
      chk("R10", "irq follows mask", irq, 1);
      wr(4'd4, 16'hFFFF);
      chk("R10", "irq low after final clear", irq, 0);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_fails++;
         $display("FAIL R2 watchdog: finished=0 expected 1");
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_arg();
      t_disabled();
      t_r1_basic();
      t_r1_err();
      t_busy_flag();
      t_long();
      t_r3();
      t_r6();
      t_stop_and_none();
      t_w1c_irq();
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
   end

endmodule